// File: doc/BRIEF.md
# Shadowed Nonvolatile SRAM Controller

A byte-wide static RAM model in which every word has a nonvolatile shadow copy. In normal operation the block behaves as a plain synchronous SRAM. Reads and writes reach only the volatile array. A bulk transfer mode copies the whole array in one direction. STORE moves every SRAM word into the shadow array. RECALL first clears the SRAM to zero and then loads it from the shadow array. While a transfer runs, the port is locked out and `busy` is high.

Transfers start from four sources:
- the falling edge of the power-good input (STORE);
- the rising edge of the power-good input (RECALL);
- the falling edge of an active-low hardware store pin (STORE);
- a six-read unlock sequence on the ordinary address port (STORE or RECALL).

The full 32768 x 8 configuration uses `ADDR_W = 15`. The default is `ADDR_W = 10` so that elaboration stays small, and the bench uses `ADDR_W = 6`.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset `busy` is 0 and `rdata` is 0.
- R2: When idle, an access with `sel=1, we=1` writes `wdata` to `addr` at the clock edge. An access with `sel=1, we=0` reads `addr`, and the data appears on `rdata` after that edge.
- R3: While `oe` is 0, `rdata` is 0.
- R4: Six consecutive reads at 0x0E, 0x31, 0x03, 0x3C, 0x23 and then 0x1F start a STORE. The addresses are the low bits, zero-extended, with `ADDR_W` >= 6. A STORE copies every SRAM word into the shadow array and keeps `busy` high for exactly DEPTH cycles.
- R5: The same five leading reads followed by a read at 0x0C start a RECALL. `busy` is then high for exactly 2*DEPTH cycles, after which every SRAM word equals its shadow word.
- R6: A write, or a read at an address that is not next in the sequence, aborts a partial sequence so that no transfer starts.
- R7: While `busy` is high, writes are ignored and `rdata` is 0.
- R8: A falling edge on `pwr_ok` starts a STORE.
- R9: A rising edge on `pwr_ok` starts a RECALL. A RECALL clears the SRAM before loading it and never changes the shadow array.
- R10: A falling edge on `hw_store_n` starts a STORE. Holding the pin low or releasing it starts nothing further.
- R11: Requests that arrive while `busy` is high are dropped and do not start a later transfer.
- R12: When a STORE request and a RECALL request arrive in the same cycle, the STORE is taken.
- R13: After reset the shadow array holds all zeros, so a RECALL before any STORE leaves the SRAM all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access strobe for the current cycle |
| we | input | 1 | 1 = write, 0 = read |
| oe | input | 1 | Read data output enable |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data; 0 when disabled or busy |
| pwr_ok | input | 1 | Power-good level |
| hw_store_n | input | 1 | Active-low hardware store request |
| busy | output | 1 | Transfer in progress |

## Verification
Random mixes of writes, enabled reads and disabled reads on a small array check plain SRAM behaviour against a bench memory model. The same model predicts SRAM and shadow contents after every STORE and RECALL. Each transfer source is exercised and its `busy` length is measured, which separates a STORE (DEPTH cycles) from a RECALL (2*DEPTH cycles). Interrupted sequences, pokes at the port during a transfer, a held hardware pin, and simultaneous store and recall triggers separate correct aborting, lockout and priority from a design that leaks a request through or takes the wrong transfer. A RECALL straight after reset, and a repeated RECALL after fresh writes, show that the shadow array starts at zero and is never changed by a RECALL.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_STORE = 2'd1,
        PH_CLEAR = 2'd2,
        PH_LOAD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic store;
        logic recall;
    } xfer_req_t;

    localparam int KEY_LEN = 5;
    localparam int STEP_W  = $clog2(KEY_LEN + 1);

    localparam logic [15:0] KEY_LEAD [KEY_LEN] = '{
        16'h000E, 16'h0031, 16'h0003, 16'h003C, 16'h0023
    };
    localparam logic [15:0] KEY_STORE  = 16'h001F;
    localparam logic [15:0] KEY_RECALL = 16'h000C;

    function automatic logic is_bulk(input phase_e p);
        return p != PH_IDLE;
    endfunction

endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] addr,
    output xfer_req_t         sw_req,
    output logic [STEP_W-1:0] step
);

    logic [STEP_W-1:0]  step_q;
    logic [STEP_W-1:0]  step_d;
    logic [KEY_LEN-1:0] lead_hit;
    logic               hit_store;
    logic               hit_recall;
    logic               at_tail;

    for (genvar i = 0; i < KEY_LEN; i++) begin : g_key
        assign lead_hit[i] = (addr == KEY_LEAD[i][ADDR_W-1:0]);
    end

    assign hit_store  = (addr == KEY_STORE[ADDR_W-1:0]);
    assign hit_recall = (addr == KEY_RECALL[ADDR_W-1:0]);
    assign at_tail    = (step_q == STEP_W'(KEY_LEN));

    always_comb begin
        step_d = step_q;
        if (acc_valid) begin
            if (acc_write) begin
                step_d = '0;
            end else if (at_tail) begin
                step_d = lead_hit[0] ? STEP_W'(1) : '0;
            end else if (lead_hit[step_q]) begin
                step_d = step_q + STEP_W'(1);
            end else begin
                step_d = lead_hit[0] ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    always_comb begin
        sw_req.store  = acc_valid & ~acc_write & at_tail & hit_store;
        sw_req.recall = acc_valid & ~acc_write & at_tail & hit_recall;
    end

    assign step = step_q;

endmodule

// File: rtl/nvs_xfer_engine.sv
module nvs_xfer_engine
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic              hw_store_n,
    input  xfer_req_t         sw_req,
    output phase_e            phase,
    output logic [ADDR_W-1:0] xidx,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] LAST = '1;

    logic              pwr_q;
    logic              hw_q;
    phase_e            phase_q;
    logic [ADDR_W-1:0] idx_q;
    logic              at_end;
    xfer_req_t         req;

    assign at_end = (idx_q == LAST);

    always_comb begin
        req.store  = (pwr_q & ~pwr_ok) | (hw_q & ~hw_store_n) | sw_req.store;
        req.recall = (~pwr_q & pwr_ok) | sw_req.recall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q   <= 1'b1;
            hw_q    <= 1'b1;
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            pwr_q <= pwr_ok;
            hw_q  <= hw_store_n;
            unique case (phase_q)
                PH_IDLE: begin
                    idx_q <= '0;
                    if (req.store)       phase_q <= PH_STORE;
                    else if (req.recall) phase_q <= PH_CLEAR;
                end
                PH_STORE: begin
                    idx_q <= idx_q + 1'b1;
                    if (at_end) phase_q <= PH_IDLE;
                end
                PH_CLEAR: begin
                    idx_q <= idx_q + 1'b1;
                    if (at_end) phase_q <= PH_LOAD;
                end
                PH_LOAD: begin
                    idx_q <= idx_q + 1'b1;
                    if (at_end) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign xidx  = idx_q;
    assign busy  = is_bulk(phase_q);

endmodule

// File: rtl/nvs_array.sv
module nvs_array
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] xidx,
    input  logic              port_we,
    input  logic              port_re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] sram   [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                sram[i]   <= '0;
                shadow[i] <= '0;
            end
        end else begin
            unique case (phase)
                PH_STORE: shadow[xidx] <= sram[xidx];
                PH_CLEAR: sram[xidx]   <= '0;
                PH_LOAD:  sram[xidx]   <= shadow[xidx];
                default: begin
                    if (port_we) sram[addr] <= wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 rd_q <= '0;
        else if (port_re)        rd_q <= sram[addr];
        else if (is_bulk(phase)) rd_q <= '0;
    end

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pwr_ok,
    input  logic              hw_store_n,
    output logic              busy
);

    phase_e            phase;
    logic [ADDR_W-1:0] xidx;
    logic [STEP_W-1:0] seq_step;
    xfer_req_t         sw_req;
    logic              acc_valid;
    logic [DATA_W-1:0] rd_q;

    assign acc_valid = sel & ~busy;

    nvs_seq_detect #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (we),
        .addr      (addr),
        .sw_req    (sw_req),
        .step      (seq_step)
    );

    nvs_xfer_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .pwr_ok     (pwr_ok),
        .hw_store_n (hw_store_n),
        .sw_req     (sw_req),
        .phase      (phase),
        .xidx       (xidx),
        .busy       (busy)
    );

    nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .xidx    (xidx),
        .port_we (acc_valid & we),
        .port_re (acc_valid & ~we),
        .addr    (addr),
        .wdata   (wdata),
        .rd_q    (rd_q)
    );

    assign rdata = (oe && !busy) ? rd_q : '0;

endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_ok,
    input logic              sel,
    input logic              we,
    input logic              busy,
    input phase_e            phase,
    input logic [ADDR_W-1:0] xidx,
    input logic [STEP_W-1:0] seq_step
);

    localparam logic [ADDR_W-1:0] LAST = '1;

    assert_store_walk_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STORE && xidx != LAST) |=>
            (phase == PH_STORE && xidx == ADDR_W'($past(xidx) + 1'b1)));

    assert_store_end_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STORE && xidx == LAST) |=> (phase == PH_IDLE));

    assert_clear_then_load_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CLEAR && xidx == LAST) |=> (phase == PH_LOAD && xidx == '0));

    assert_write_aborts_R6: assert property (@(posedge clk) disable iff (rst)
        (sel && we && !busy) |=> (seq_step == '0));

    assert_power_fail_store_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && $fell(pwr_ok)) |=> (phase == PH_STORE));

    assert_fresh_start_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (phase == PH_IDLE || xidx == '0));

endmodule

bind nvs_ctrl nvs_ctrl_chk #(.ADDR_W(ADDR_W)) i_nvs_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_ok   (pwr_ok),
    .sel      (sel),
    .we       (we),
    .busy     (busy),
    .phase    (phase),
    .xidx     (xidx),
    .seq_step (seq_step)
);

// File: tb/test_nvs_ctrl.sv
`timescale 1ns/1ps
module test_nvs_ctrl;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    localparam logic [AW-1:0] K0 = 6'h0E, K1 = 6'h31, K2 = 6'h03, K3 = 6'h3C, K4 = 6'h23;
    localparam logic [AW-1:0] KS = 6'h1F, KR = 6'h0C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0, we = 1'b0, oe = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          pwr_ok = 1'b1, hw_store_n = 1'b1;
    logic          busy;

    logic [DW-1:0] sram_m   [DEPTH];
    logic [DW-1:0] shadow_m [DEPTH];
    int nvec = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    nvs_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_nvs_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .oe(oe), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwr_ok(pwr_ok), .hw_store_n(hw_store_n),
        .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; we = 1'b0;
        sram_m[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); sel = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] d;
        rd(a, d);
        chk(req, int'(d), int'(sram_m[a]));
    endtask

    task automatic seq(input logic [AW-1:0] last);
        logic [DW-1:0] d;
        rd(K0, d); rd(K1, d); rd(K2, d); rd(K3, d); rd(K4, d); rd(last, d);
    endtask

    task automatic wait_busy(input int exp, input string req, input bit poke);
        int n = 0;
        while (busy && n < 4 * DEPTH) begin
            n++;
            if (poke) begin
                case (n)
                    2: begin sel = 1'b1; we = 1'b1; addr = 6'd5; wdata = ~sram_m[5]; end
                    3: begin we = 1'b0; hw_store_n = 1'b0; end
                    4: begin sel = 1'b0; hw_store_n = 1'b1; chk("R7 rdata while busy", int'(rdata), 0); end
                    default: ;
                endcase
            end
            @(negedge clk);
        end
        chk(req, n, exp);
        @(negedge clk);
        chk({req, " no restart"}, int'(busy), 0);
    endtask

    task automatic fill_random();
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), DW'($urandom));
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < DEPTH; a++) rd_chk(AW'(a), req);
    endtask

    task automatic snap_store();
        for (int a = 0; a < DEPTH; a++) shadow_m[a] = sram_m[a];
    endtask

    task automatic snap_recall();
        for (int a = 0; a < DEPTH; a++) sram_m[a] = shadow_m[a];
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd4242));
        for (int a = 0; a < DEPTH; a++) begin sram_m[a] = '0; shadow_m[a] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 rdata after reset", int'(rdata), 0);

        // R2 / R3: random SRAM traffic
        for (int i = 0; i < 200; i++) begin
            automatic logic [AW-1:0] a = AW'($urandom % DEPTH);
            automatic int op = int'($urandom % 3);
            if (op == 0) wr(a, DW'($urandom));
            else if (op == 1) rd_chk(a, "R2 read");
            else begin
                oe = 1'b0; rd(a, d);
                chk("R3 oe low", int'(d), 0);
                oe = 1'b1;
            end
        end

        // R13: recall before any store gives zeros
        seq(KR);
        wait_busy(2 * DEPTH, "R5 recall length", 1'b0);
        snap_recall();
        check_all("R13 zero shadow");

        // R4 + R7 + R11: software store with pokes while busy
        fill_random();
        seq(KS);
        wait_busy(DEPTH, "R4 store length", 1'b1);
        snap_store();
        rd_chk(6'd5, "R7 write ignored");

        // R6: aborted sequences
        rd(K0, d); rd(K1, d); rd(K2, d);
        wr(6'h20, 8'hA5);
        rd(K3, d); rd(K4, d); rd(KS, d);
        chk("R6 write abort", int'(busy), 0);
        rd(K0, d); rd(K1, d); rd(K2, d); rd(6'h20, d); rd(K3, d); rd(K4, d); rd(KR, d);
        chk("R6 read abort", int'(busy), 0);

        // R5 + R9: recall restores shadow, shadow unchanged
        fill_random();
        seq(KR);
        wait_busy(2 * DEPTH, "R5 recall length", 1'b0);
        snap_recall();
        check_all("R5 recall data");
        fill_random();
        seq(KR);
        wait_busy(2 * DEPTH, "R9 second recall", 1'b0);
        snap_recall();
        check_all("R9 shadow untouched");

        // R8 / R9: power cycle
        fill_random();
        @(negedge clk); pwr_ok = 1'b0;
        @(negedge clk);
        wait_busy(DEPTH, "R8 power-fail store", 1'b0);
        snap_store();
        fill_random();
        @(negedge clk); pwr_ok = 1'b1;
        @(negedge clk);
        wait_busy(2 * DEPTH, "R9 power-up recall", 1'b0);
        snap_recall();
        check_all("R9 power-up data");

        // R10: hardware pin
        fill_random();
        @(negedge clk); hw_store_n = 1'b0;
        @(negedge clk);
        wait_busy(DEPTH, "R10 pin store", 1'b0);
        snap_store();
        repeat (4) @(negedge clk);
        chk("R10 pin held low", int'(busy), 0);
        hw_store_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 pin release", int'(busy), 0);
        fill_random();
        seq(KR);
        wait_busy(2 * DEPTH, "R10 recall length", 1'b0);
        snap_recall();
        check_all("R10 pin store data");

        // R12: simultaneous store and recall requests
        @(negedge clk); pwr_ok = 1'b0;
        @(negedge clk);
        wait_busy(DEPTH, "R8 power-fail store", 1'b0);
        snap_store();
        fill_random();
        @(negedge clk); pwr_ok = 1'b1; hw_store_n = 1'b0;
        @(negedge clk);
        wait_busy(DEPTH, "R12 store wins", 1'b0);
        snap_store();
        hw_store_n = 1'b1;
        fill_random();
        seq(KR);
        wait_busy(2 * DEPTH, "R12 recall length", 1'b0);
        snap_recall();
        check_all("R12 store data");

        report();
    end

endmodule